// File: doc/BRIEF.md
# I2C Bus Clock Rate Divider

This block turns a fast system clock into the timing skeleton of an I2C master's bus clock. A rate setting is split into a linear factor `m` and an exponent `n`. The system clock is first divided by `m+1`, and the result is then divided by `2^(n+1)`. Each resulting strobe is one tick, and ten ticks make one SCL period. The bus clock frequency is therefore the system clock divided by `10·(m+1)·2^(n+1)`.

The block numbers the ticks of each period from 0 to 9 and raises a one-cycle marker on the ticks where the master state machine acts:
- SCL falls on tick 0.
- SDA may change on tick 2.
- SCL rises on tick 5.
- SDA is sampled on tick 7.

A registered SCL level is also provided, so the master can drive the bus pin from it directly.

The rate setting arrives on an input port. It is taken into use only at the boundary between two SCL periods, or continuously while the block is held off. After a reset the block forgets any earlier setting and falls back to `m=4, n=4`.

Top module: `scl_rate_divider`

## Requirements
- R1: While running, consecutive `tick` pulses are exactly `(m+1)·2^(n+1)` system clock cycles apart, so one 10-tick SCL period lasts `10·(m+1)·2^(n+1)` cycles.
- R2: `rate_cfg` carries `m` in bits 6:3 (0 to 15) and `n` in bits 2:0 (0 to 7). Every combination is honoured, including `m=0, n=0` and `m=15, n=7`.
- R3: During and after a synchronous reset:
  - the active setting is `m=4, n=4`, so ticks are 160 cycles apart;
  - `tick` and all markers are low;
  - `tick_phase` is 0;
  - `scl_level` is high.
- R4: A change of `rate_cfg` while running has no effect until the tick with phase 9 has occurred; the following gap already uses the new setting.
- R5: `tick_phase` gives the index of the current tick. The index runs 0,1,…,9 and then wraps back to 0.
- R6: Each marker is a one-cycle pulse that coincides with a `tick` of one particular phase:
  - `scl_fall` with phase 0;
  - `sda_shift` with phase 2;
  - `scl_rise` with phase 5;
  - `sda_sample` with phase 7.
- R7: `scl_level` goes low with the phase-0 tick and high with the phase-5 tick. It is held high in reset and while halted.
- R8: While `halt` is high:
  - both counters hold at zero;
  - no tick or marker is produced;
  - `tick_phase` is 0;
  - `rate_cfg` is loaded every cycle.
- R9: After reset or `halt` is released, the first tick arrives exactly one full tick interval later and carries phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| halt | input | 1 | Holds counters at zero and suppresses ticks |
| rate_cfg | input | 7 | Rate setting: m in bits 6:3, n in bits 2:0 |
| tick | output | 1 | One-cycle tick strobe, ten per SCL period |
| tick_phase | output | 4 | Index 0..9 of the latest tick |
| scl_fall | output | 1 | Marker on the phase-0 tick |
| sda_shift | output | 1 | Marker on the phase-2 tick |
| scl_rise | output | 1 | Marker on the phase-5 tick |
| sda_sample | output | 1 | Marker on the phase-7 tick |
| scl_level | output | 1 | Registered SCL level |

## Verification
The bench builds the block with its default widths: a 4-bit linear field and a 3-bit exponent field. With these widths the fastest setting (2 cycles per tick) and the slowest (4096 cycles per tick) are both reachable within a short run. Tick gaps are measured at both extremes and at intermediate settings. A rate change is made part-way through a period to show that it waits for the period boundary.

// File: rtl/sclr_pkg.sv
package sclr_pkg;

    localparam int TICKS_PER_PERIOD = 10;
    localparam int PHASE_W          = 4;
    localparam int LAST_PHASE       = TICKS_PER_PERIOD - 1;

    localparam int FALL_PHASE   = 0;
    localparam int SHIFT_PHASE  = 2;
    localparam int RISE_PHASE   = 5;
    localparam int SAMPLE_PHASE = 7;

    localparam int DEF_M = 4;
    localparam int DEF_N = 4;

    typedef struct packed {
        logic fall;
        logic shift;
        logic rise;
        logic sample;
    } mark_t;

    function automatic mark_t decode_marks(input logic [PHASE_W-1:0] ph);
        mark_t r;
        r.fall   = (ph == PHASE_W'(FALL_PHASE));
        r.shift  = (ph == PHASE_W'(SHIFT_PHASE));
        r.rise   = (ph == PHASE_W'(RISE_PHASE));
        r.sample = (ph == PHASE_W'(SAMPLE_PHASE));
        return r;
    endfunction

    function automatic logic [PHASE_W-1:0] next_phase(input logic [PHASE_W-1:0] ph);
        return (ph == PHASE_W'(LAST_PHASE)) ? '0 : ph + 1'b1;
    endfunction

endpackage

// File: rtl/sclr_lin_stage.sv
module sclr_lin_stage #(
    parameter int M_W = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic [M_W-1:0] m_lim,
    output logic           carry
);
    logic [M_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == m_lim) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign carry = run && (cnt == m_lim);

    // R1: linear count never passes its limit
    p_lin_bound_r1: assert property (@(posedge clk) disable iff (rst)
        cnt <= m_lim);

    // R8: a halted stage is parked at zero
    p_lin_park_r8: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));
endmodule

// File: rtl/sclr_pow_stage.sv
module sclr_pow_stage #(
    parameter int N_W = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic           step,
    input  logic [N_W-1:0] n_sel,
    output logic           wrap
);
    localparam int PW = 1 << N_W;

    logic [PW-1:0] cnt;
    logic [PW:0]   span;
    logic [PW-1:0] last;

    assign span = (PW+1)'(2) << n_sel;
    assign last = PW'(span - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= (cnt == last) ? '0 : cnt + 1'b1;
        end
    end

    assign wrap = step && (cnt == last);

    // R1: power-of-two count stays inside 2^(n+1)
    p_pow_bound_r1: assert property (@(posedge clk) disable iff (rst)
        cnt <= last);

    // R1: the stage advances only on a carry from the linear stage
    p_pow_step_r1: assert property (@(posedge clk) disable iff (rst)
        (run && !step) |=> $stable(cnt));
endmodule

// File: rtl/sclr_phase_seq.sv
module sclr_phase_seq
    import sclr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               wrap,
    output logic               period_end,
    output logic               tick,
    output logic [PHASE_W-1:0] tick_phase,
    output mark_t              marks,
    output logic               scl_level
);
    logic [PHASE_W-1:0] upcoming;

    assign period_end = wrap && (upcoming == PHASE_W'(LAST_PHASE));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            upcoming   <= '0;
            tick       <= 1'b0;
            tick_phase <= '0;
            marks      <= '0;
            scl_level  <= 1'b1;
        end else begin
            tick  <= wrap;
            marks <= wrap ? decode_marks(upcoming) : '0;
            if (wrap) begin
                tick_phase <= upcoming;
                upcoming   <= next_phase(upcoming);
                if (upcoming == PHASE_W'(FALL_PHASE)) scl_level <= 1'b0;
                if (upcoming == PHASE_W'(RISE_PHASE)) scl_level <= 1'b1;
            end
        end
    end

    // R5: reported index stays within one period
    p_phase_range_r5: assert property (@(posedge clk) disable iff (rst)
        tick_phase <= PHASE_W'(LAST_PHASE));

    // R6: markers are exclusive and only ride on a tick
    p_mark_excl_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(marks));
    p_mark_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
        (marks != '0) |-> tick);

    // R7: bus level follows the fall and rise markers
    p_scl_fall_r7: assert property (@(posedge clk) disable iff (rst)
        marks.fall |-> !scl_level);
    p_scl_rise_r7: assert property (@(posedge clk) disable iff (rst)
        marks.rise |-> scl_level);

    // R8: halted sequencer is quiet and keeps SCL high
    p_halt_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!tick && scl_level && tick_phase == '0));
endmodule

// File: rtl/scl_rate_divider.sv
module scl_rate_divider
    import sclr_pkg::*;
#(
    parameter int M_W   = 4,
    parameter int N_W   = 3,
    parameter int M_RST = DEF_M,
    parameter int N_RST = DEF_N
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               halt,
    input  logic [M_W+N_W-1:0] rate_cfg,
    output logic               tick,
    output logic [PHASE_W-1:0] tick_phase,
    output logic               scl_fall,
    output logic               sda_shift,
    output logic               scl_rise,
    output logic               sda_sample,
    output logic               scl_level
);
    localparam int CFG_W = M_W + N_W;

    logic [M_W-1:0] m_act;
    logic [N_W-1:0] n_act;
    logic           run;
    logic           carry;
    logic           wrap;
    logic           period_end;
    mark_t          marks;

    assign run = !halt;

    always_ff @(posedge clk) begin
        if (rst) begin
            m_act <= M_W'(M_RST);
            n_act <= N_W'(N_RST);
        end else if (halt || period_end) begin
            m_act <= rate_cfg[CFG_W-1:N_W];
            n_act <= rate_cfg[N_W-1:0];
        end
    end

    sclr_lin_stage #(.M_W(M_W)) u_lin (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .m_lim (m_act),
        .carry (carry)
    );

    sclr_pow_stage #(.N_W(N_W)) u_pow (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .step  (carry),
        .n_sel (n_act),
        .wrap  (wrap)
    );

    sclr_phase_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .wrap       (wrap),
        .period_end (period_end),
        .tick       (tick),
        .tick_phase (tick_phase),
        .marks      (marks),
        .scl_level  (scl_level)
    );

    assign scl_fall   = marks.fall;
    assign sda_shift  = marks.shift;
    assign scl_rise   = marks.rise;
    assign sda_sample = marks.sample;

    // R4: the active setting moves only at a period boundary or while halted
    p_cfg_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!halt && !period_end) |=> ($stable(m_act) && $stable(n_act)));

    // R9: a released halt yields no tick in the very next cycle
    p_release_gap_r9: assert property (@(posedge clk) disable iff (rst)
        halt |=> !tick);
endmodule

// File: tb/scl_rate_divider_test.sv
module scl_rate_divider_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       halt = 1'b0;
    logic [6:0] rate_cfg = '0;
    logic       tick;
    logic [3:0] tick_phase;
    logic       scl_fall, sda_shift, scl_rise, sda_sample, scl_level;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    scl_rate_divider uut (
        .clk(clk), .rst(rst), .halt(halt), .rate_cfg(rate_cfg),
        .tick(tick), .tick_phase(tick_phase),
        .scl_fall(scl_fall), .sda_shift(sda_shift),
        .scl_rise(scl_rise), .sda_sample(sda_sample),
        .scl_level(scl_level)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // behavioural reference: one flat cycle counter per tick
    int r_cnt = 0, r_idx = 0, r_m = 4, r_n = 4;
    bit e_tick = 0, e_scl = 1, e_fall = 0, e_shift = 0, e_rise = 0, e_samp = 0;
    int e_phase = 0;
    bit model_ok = 0;

    always @(posedge clk) begin
        cyc++;
        e_tick = 0; e_fall = 0; e_shift = 0; e_rise = 0; e_samp = 0;
        if (rst) begin
            r_cnt = 0; r_idx = 0; r_m = 4; r_n = 4; e_phase = 0; e_scl = 1;
        end else if (halt) begin
            r_cnt = 0; r_idx = 0; e_phase = 0; e_scl = 1;
            r_m = int'(rate_cfg[6:3]); r_n = int'(rate_cfg[2:0]);
        end else begin
            r_cnt++;
            if (r_cnt == (r_m + 1) * (2 ** (r_n + 1))) begin
                r_cnt = 0;
                e_tick = 1;
                e_phase = r_idx;
                e_fall = (r_idx == 0); e_shift = (r_idx == 2);
                e_rise = (r_idx == 5); e_samp = (r_idx == 7);
                if (r_idx == 0) e_scl = 0;
                if (r_idx == 5) e_scl = 1;
                if (r_idx == 9) begin
                    r_idx = 0;
                    r_m = int'(rate_cfg[6:3]); r_n = int'(rate_cfg[2:0]);
                end else begin
                    r_idx++;
                end
            end
        end
        model_ok = 1;
    end

    always @(negedge clk) begin
        if (model_ok) begin
            chk(tick == e_tick, "R1 tick", int'(tick), int'(e_tick));
            chk(tick_phase == 4'(e_phase), "R5 tick_phase", int'(tick_phase), e_phase);
            chk(scl_fall == e_fall && sda_shift == e_shift, "R6 fall/shift",
                int'({scl_fall, sda_shift}), int'({e_fall, e_shift}));
            chk(scl_rise == e_rise && sda_sample == e_samp, "R6 rise/sample",
                int'({scl_rise, sda_sample}), int'({e_rise, e_samp}));
            chk(scl_level == e_scl, "R7 scl_level", int'(scl_level), int'(e_scl));
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // cycles until the next visible tick
    task automatic gap_to_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick);
    endtask

    task automatic wait_phase(input int p);
        do @(negedge clk); while (!(tick && tick_phase == 4'(p)));
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic restart(input int m, input int n, input string tag);
        int g;
        halt = 1'b1;
        rate_cfg = {4'(m), 3'(n)};
        run_cycles(20);
        chk(tick == 0 && scl_level == 1, {tag, " R8 halted quiet"}, int'(tick), 0);
        halt = 1'b0;
        gap_to_tick(g);
        chk(g == (m + 1) * (2 ** (n + 1)), {tag, " R9 first gap"}, g, (m + 1) * (2 ** (n + 1)));
        chk(tick_phase == 0, {tag, " R9 first phase"}, int'(tick_phase), 0);
        gap_to_tick(g);
        chk(g == (m + 1) * (2 ** (n + 1)), {tag, " R1 R2 gap"}, g, (m + 1) * (2 ** (n + 1)));
    endtask

    initial begin
        int g;
        run_cycles(3);
        chk(tick == 0 && tick_phase == 0, "R3 reset outputs", int'({tick, tick_phase}), 0);
        chk(scl_level == 1, "R3 reset scl", int'(scl_level), 1);
        rst = 1'b0;
        gap_to_tick(g);
        chk(g == 160, "R3 R9 default first gap", g, 160);
        gap_to_tick(g);
        chk(g == 160, "R1 R3 default gap", g, 160);
        run_cycles(2000);

        restart(0, 0, "m0n0");
        run_cycles(100);
        restart(3, 1, "m3n1");
        run_cycles(300);

        // R4: change mid-period, old spacing holds until the phase-9 tick
        wait_phase(3);
        rate_cfg = {4'd2, 3'd0};
        gap_to_tick(g);
        chk(g == 16, "R4 old spacing kept", g, 16);
        wait_phase(9);
        gap_to_tick(g);
        chk(g == 6, "R4 new spacing after boundary", g, 6);
        chk(tick_phase == 0, "R5 wrap to 0", int'(tick_phase), 0);
        run_cycles(200);

        restart(1, 5, "m1n5");
        restart(15, 7, "m15n7");
        wait_phase(5);
        chk(scl_level == 1, "R7 high after rise", int'(scl_level), 1);

        // halt mid-run then resume
        restart(0, 0, "resume");
        run_cycles(50);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule